// File: doc/BRIEF.md
# Hall-Commutated Three-Phase PWM Gate Controller

This block turns three digitized Hall-sensor bits, a rotation-direction input, a run/halt input and an active-low external PWM input into gate-enable signals for the three half-bridges of a brushless motor stage. Each leg is placed in one of three states: high side on (sourcing), low side on (sinking) or fully off. PWM chopping acts only on the high-side switch of the sourcing leg. During the PWM off time the low side of that same leg can be turned on as a synchronous rectifier. A programmable dead time always separates the turn-off of one switch of a leg from the turn-on of its complement.

A small monitor measures the period and the on time of the external PWM input. It allows synchronous rectification only while the PWM rate is fast enough and the on-duty is not too small. Protection requests (stall, current limit, undervoltage, overtemperature) arrive as plain flags that override the commutation. The halt input applies a short brake. One Hall channel is echoed on an open-drain speed-feedback output, modelled as an active-low pull enable. All outputs are registered, so every output reacts one clock after the inputs that cause it.

Top module: `bldc_gate_ctrl`

## Requirements
- R1: With `dir_rev`=0 the Hall code `hall` (bit 0 = leg U, bit 1 = leg V, bit 2 = leg W) selects the source and sink legs as follows: 001 U source / V sink, 011 U / W, 010 V / W, 110 V / U, 100 W / U, 101 W / V. The third leg is off. Output bit i of `hs_en`/`ls_en` belongs to the same leg as `hall` bit i.
- R2: With `dir_rev`=1 the same Hall code swaps the roles, so the R1 sink leg sources and the R1 source leg sinks.
- R3: Hall codes 000 and 111 turn all six switches off one clock later, unless halt or undervoltage/overtemperature takes precedence.
- R4: `pwm_n` is active low. While it is 0 the sourcing leg's high side is on. While it is 1 that high side is off one clock later. The sinking leg's low side stays on regardless of `pwm_n`.
- R5: While synchronous rectification is enabled, the sourcing leg's low side turns on during PWM off time, once the dead time has elapsed.
- R6: Synchronous rectification is enabled at a falling edge of `pwm_n` only if the finished period was at most PER_MAX clocks and its low time was at least ON_MIN clocks. It is disabled one clock after `pwm_n` has gone PER_MAX+1 clocks without a falling edge, and it is disabled after reset.
- R7: The high and low enables of a leg are never both 1. After one switch of a leg turns off, its complement stays off for at least DEAD_CYC clocks (default 8).
- R8: With `stop_req`=1 all high sides are off one clock later and all low sides turn on (short brake), subject to the dead time.
- R9: `flt_stall` or `flt_ilim` forces every high side off one clock later, and the sourcing leg's low side is also released.
- R10: `flt_uv` or `flt_ot` forces all six switches off one clock later. This takes precedence over halt.
- R11: `fb_od_n` equals `hall` bit 0 delayed by one clock (0 = pin pulled low).
- R12: During synchronous reset all enables are 0 and `fb_od_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall | input | 3 | Digitized Hall bits (1 when positive input exceeds negative) |
| dir_rev | input | 1 | 1 selects the reverse commutation table |
| stop_req | input | 1 | 1 (or undriven, pulled high) halts with short brake |
| pwm_n | input | 1 | External PWM, 0 = high side on |
| flt_stall | input | 1 | Stall protection request |
| flt_ilim | input | 1 | Current-limit request |
| flt_uv | input | 1 | Undervoltage request |
| flt_ot | input | 1 | Overtemperature request |
| hs_en | output | 3 | High-side gate enables, bit per leg U/V/W |
| ls_en | output | 3 | Low-side gate enables, bit per leg U/V/W |
| fb_od_n | output | 1 | Speed feedback open-drain enable, 0 pulls low |

## Verification
The sharpest overlap is a protection request arriving in the very cycle that a leg's dead time expires and its high side is due to switch on. The high side must stay off and the low side must not recover. The bench provokes this by leaving a short brake with full drive and then sweeping a one-cycle stall pulse across every offset of the dead-time window. A second overlap is a falling PWM edge that re-qualifies synchronous rectification in the same cycle the off-phase low side would engage. Both overlaps are judged by a cycle-by-cycle behavioural reference model compared on every clock.

// File: rtl/bldc_gate_pkg.sv
package bldc_gate_pkg;
  localparam int NUM_LEGS = 3;

  typedef enum logic [1:0] {
    ROLE_OFF = 2'd0,
    ROLE_SRC = 2'd1,
    ROLE_SNK = 2'd2
  } role_t;
endpackage

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_gate_pkg::*;
(
  input  logic                       [2:0] hall_i,
  input  logic                             rev_i,
  output role_t [NUM_LEGS-1:0]             role_o
);
  logic [1:0] fwd_hi, fwd_lo, hi_sel, lo_sel;
  logic       valid;

  // forward table: which leg sources and which sinks for each legal code
  always_comb begin
    valid  = 1'b1;
    fwd_hi = 2'd0;
    fwd_lo = 2'd0;
    unique case (hall_i)
      3'b001: begin fwd_hi = 2'd0; fwd_lo = 2'd1; end
      3'b011: begin fwd_hi = 2'd0; fwd_lo = 2'd2; end
      3'b010: begin fwd_hi = 2'd1; fwd_lo = 2'd2; end
      3'b110: begin fwd_hi = 2'd1; fwd_lo = 2'd0; end
      3'b100: begin fwd_hi = 2'd2; fwd_lo = 2'd0; end
      3'b101: begin fwd_hi = 2'd2; fwd_lo = 2'd1; end
      default: valid = 1'b0;
    endcase
  end

  // reverse direction swaps the source and sink legs
  assign hi_sel = rev_i ? fwd_lo : fwd_hi;
  assign lo_sel = rev_i ? fwd_hi : fwd_lo;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_role
    assign role_o[g] = !valid              ? ROLE_OFF :
                       (hi_sel == 2'(g))   ? ROLE_SRC :
                       (lo_sel == 2'(g))   ? ROLE_SNK : ROLE_OFF;
  end
endmodule

// File: rtl/bldc_pwm_monitor.sv
module bldc_pwm_monitor #(
  parameter int PER_MAX = 13333,
  parameter int ON_MIN  = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_n_i,
  output logic sync_ok_o
);
  localparam int SAT = PER_MAX + 1;
  localparam int CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);
  localparam logic [CW-1:0] MAX_V = CW'(PER_MAX);
  localparam logic [CW-1:0] MIN_V = CW'(ON_MIN);

  logic          pwm_d;
  logic [CW-1:0] per_cnt;
  logic [CW-1:0] on_len;
  logic          sync_q;
  logic          fall, rise;

  assign fall = pwm_d & ~pwm_n_i;   // start of high-side on time
  assign rise = ~pwm_d & pwm_n_i;   // start of off time

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_d   <= 1'b1;
      per_cnt <= SAT_V;
      on_len  <= '0;
      sync_q  <= 1'b0;
    end else begin
      pwm_d <= pwm_n_i;
      if (rise)
        on_len <= per_cnt;
      if (fall)
        sync_q <= (per_cnt <= MAX_V) && (on_len >= MIN_V);
      else if (per_cnt == SAT_V)
        sync_q <= 1'b0;
      if (fall)
        per_cnt <= CW'(1);
      else if (per_cnt != SAT_V)
        per_cnt <= per_cnt + CW'(1);
    end
  end

  assign sync_ok_o = sync_q;

  // R6: qualification only ever happens on a falling PWM edge
  p_sync_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_q) |-> $past(fall));
endmodule

// File: rtl/bldc_leg.sv
module bldc_leg #(
  parameter int DEAD_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic want_hi_i,
  input  logic want_lo_i,
  output logic hs_o,
  output logic ls_o
);
  localparam int DW = $clog2(DEAD_CYC + 2);
  localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CYC);

  logic          hs_q, ls_q, hs_n, ls_n;
  logic [DW-1:0] dt_q;

  // turn-off is immediate; turn-on waits for complement off and timer idle
  always_comb begin
    if (!want_hi_i)  hs_n = 1'b0;
    else if (hs_q)   hs_n = 1'b1;
    else             hs_n = !ls_q && (dt_q == '0);
    if (!want_lo_i)  ls_n = 1'b0;
    else if (ls_q)   ls_n = 1'b1;
    else             ls_n = !hs_q && (dt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
      dt_q <= '0;
    end else begin
      hs_q <= hs_n;
      ls_q <= ls_n;
      if ((hs_q && !hs_n) || (ls_q && !ls_n))
        dt_q <= DEAD_V;
      else if (dt_q != '0)
        dt_q <= dt_q - DW'(1);
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  // independent gap counters: cycles each switch has been off (capped)
  logic [DW-1:0] gap_hi, gap_lo;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_hi <= DEAD_V;
      gap_lo <= DEAD_V;
    end else begin
      if (hs_q)                gap_hi <= '0;
      else if (gap_hi != DEAD_V) gap_hi <= gap_hi + DW'(1);
      if (ls_q)                gap_lo <= '0;
      else if (gap_lo != DEAD_V) gap_lo <= gap_lo + DW'(1);
    end
  end

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    !(hs_q && ls_q));
  p_gap_before_low_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_q) |-> (gap_hi >= DEAD_V));
  p_gap_before_high_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_q) |-> (gap_lo >= DEAD_V));
endmodule

// File: rtl/bldc_gate_ctrl.sv
module bldc_gate_ctrl
  import bldc_gate_pkg::*;
#(
  parameter int DEAD_CYC = 8,
  parameter int PER_MAX  = 13333,
  parameter int ON_MIN   = 150
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] hall,
  input  logic       dir_rev,
  input  logic       stop_req,
  input  logic       pwm_n,
  input  logic       flt_stall,
  input  logic       flt_ilim,
  input  logic       flt_uv,
  input  logic       flt_ot,
  output logic [2:0] hs_en,
  output logic [2:0] ls_en,
  output logic       fb_od_n
);
  role_t [NUM_LEGS-1:0] role;
  logic                 sync_ok;
  logic                 pwm_on, hard_off, hs_block;

  bldc_commutator u_comm (
    .hall_i (hall),
    .rev_i  (dir_rev),
    .role_o (role)
  );

  bldc_pwm_monitor #(.PER_MAX(PER_MAX), .ON_MIN(ON_MIN)) u_mon (
    .clk       (clk),
    .rst       (rst),
    .pwm_n_i   (pwm_n),
    .sync_ok_o (sync_ok)
  );

  assign pwm_on   = ~pwm_n;
  assign hard_off = flt_uv | flt_ot;
  assign hs_block = flt_stall | flt_ilim;

  // priority: supply/thermal off > halt brake > commutation
  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    logic want_hi, want_lo;
    always_comb begin
      want_hi = 1'b0;
      want_lo = 1'b0;
      if (!hard_off) begin
        if (stop_req) begin
          want_lo = 1'b1;
        end else if (role[g] == ROLE_SRC) begin
          want_hi = pwm_on & ~hs_block;
          want_lo = ~pwm_on & sync_ok & ~hs_block;
        end else if (role[g] == ROLE_SNK) begin
          want_lo = 1'b1;
        end
      end
    end

    bldc_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk       (clk),
      .rst       (rst),
      .want_hi_i (want_hi),
      .want_lo_i (want_lo),
      .hs_o      (hs_en[g]),
      .ls_o      (ls_en[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) fb_od_n <= 1'b1;
    else     fb_od_n <= hall[0];
  end

  p_flags_kill_high_r9: assert property (@(posedge clk) disable iff (rst)
    (flt_stall | flt_ilim | flt_uv | flt_ot) |=> (hs_en == 3'b000));
  p_supply_all_off_r10: assert property (@(posedge clk) disable iff (rst)
    (flt_uv | flt_ot) |=> ((hs_en | ls_en) == 3'b000));
  p_halt_no_high_r8: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> (hs_en == 3'b000));
  p_bad_code_off_r3: assert property (@(posedge clk) disable iff (rst)
    (((hall == 3'b000) || (hall == 3'b111)) && !stop_req) |=> ((hs_en | ls_en) == 3'b000));
  p_fb_follows_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (fb_od_n == $past(hall[0])));
endmodule

// File: tb/bldc_gate_ctrl_test.sv
`timescale 1ns/1ps
module bldc_gate_ctrl_test;
  localparam int DEAD = 8;
  localparam int PMAX = 400;
  localparam int OMIN = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hall = 3'b001;
  logic       dir_rev = 1'b0, stop_req = 1'b1, pwm_n = 1'b1;
  logic       flt_stall = 1'b0, flt_ilim = 1'b0, flt_uv = 1'b0, flt_ot = 1'b0;
  logic [2:0] hs_en, ls_en;
  logic       fb_od_n;

  int total = 0, bad = 0;
  bit cmp_en = 0, done = 0;
  string cur_req = "R12";

  always #5 clk = ~clk;

  bldc_gate_ctrl #(.DEAD_CYC(DEAD), .PER_MAX(PMAX), .ON_MIN(OMIN)) uut (
    .clk(clk), .rst(rst), .hall(hall), .dir_rev(dir_rev), .stop_req(stop_req),
    .pwm_n(pwm_n), .flt_stall(flt_stall), .flt_ilim(flt_ilim), .flt_uv(flt_uv),
    .flt_ot(flt_ot), .hs_en(hs_en), .ls_en(ls_en), .fb_od_n(fb_od_n));

  // ---------------- behavioural reference model ----------------
  int m_per = PMAX + 1, m_on = 0;
  bit m_sync = 0, m_pd = 1, m_fb = 1;
  bit [2:0] m_hs = 0, m_ls = 0;
  int m_cnt [3] = '{0, 0, 0};

  // 1 = source, 2 = sink, 0 = off
  function automatic int leg_role(logic [2:0] h, logic rev, int leg);
    int s, k;
    s = -1; k = -1;
    case (h)
      3'b001: begin s = 0; k = 1; end
      3'b011: begin s = 0; k = 2; end
      3'b010: begin s = 1; k = 2; end
      3'b110: begin s = 1; k = 0; end
      3'b100: begin s = 2; k = 0; end
      3'b101: begin s = 2; k = 1; end
      default: ;
    endcase
    if (rev) begin int t; t = s; s = k; k = t; end
    if (leg == s) return 1;
    if (leg == k) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_per = PMAX + 1; m_on = 0; m_sync = 0; m_pd = 1; m_fb = 1;
      m_hs = 0; m_ls = 0;
      for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    end else begin
      bit fall, rise;
      for (int i = 0; i < 3; i++) begin
        bit th, tl, hn, ln;
        int r;
        th = 0; tl = 0;
        r = leg_role(hall, dir_rev, i);
        if (flt_uv || flt_ot) begin th = 0; tl = 0; end
        else if (stop_req) tl = 1;
        else if (r == 1) begin
          th = !pwm_n && !(flt_stall || flt_ilim);
          tl = pwm_n && m_sync && !(flt_stall || flt_ilim);
        end else if (r == 2) tl = 1;
        if (!th) hn = 0; else if (m_hs[i]) hn = 1; else hn = !m_ls[i] && m_cnt[i] == 0;
        if (!tl) ln = 0; else if (m_ls[i]) ln = 1; else ln = !m_hs[i] && m_cnt[i] == 0;
        if ((m_hs[i] && !hn) || (m_ls[i] && !ln)) m_cnt[i] = DEAD;
        else if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
        m_hs[i] = hn; m_ls[i] = ln;
      end
      fall = m_pd && !pwm_n;
      rise = !m_pd && pwm_n;
      if (rise) m_on = m_per;
      if (fall) m_sync = (m_per <= PMAX) && (m_on >= OMIN);
      else if (m_per == PMAX + 1) m_sync = 0;
      if (fall) m_per = 1; else if (m_per != PMAX + 1) m_per = m_per + 1;
      m_pd = pwm_n;
      m_fb = hall[0];
    end
  end

  // per-cycle comparison plus an independent overlap watch (R7)
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      total++;
      if (hs_en !== m_hs || ls_en !== m_ls || fb_od_n !== m_fb) begin
        bad++;
        $display("FAIL %s cycle compare: hs=%b ls=%b fb=%b expected hs=%b ls=%b fb=%b",
                 cur_req, hs_en, ls_en, fb_od_n, m_hs, m_ls, m_fb);
      end
      total++;
      if ((hs_en & ls_en) !== 3'b000) begin
        bad++;
        $display("FAIL R7 overlap: hs=%b ls=%b expected no common bit", hs_en, ls_en);
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string tag, logic [2:0] ehs, logic [2:0] els);
    @(negedge clk);
    total++;
    if (hs_en !== ehs || ls_en !== els) begin
      bad++;
      $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", tag, hs_en, ls_en, ehs, els);
    end
  endtask

  task automatic expect_fb(string tag, logic e);
    @(negedge clk);
    total++;
    if (fb_od_n !== e) begin
      bad++;
      $display("FAIL %s: fb=%b expected %b", tag, fb_od_n, e);
    end
  endtask

  task automatic pwm_periods(int per, int on, int n);
    for (int k = 0; k < n; k++) begin
      pwm_n = 1'b0; run(on);
      pwm_n = 1'b1; run(per - on);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    logic [2:0] codes [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
    logic [2:0] ehs   [6] = '{3'b001, 3'b001, 3'b010, 3'b010, 3'b100, 3'b100};
    logic [2:0] els   [6] = '{3'b010, 3'b100, 3'b100, 3'b001, 3'b001, 3'b010};

    @(posedge clk); #1;
    cmp_en = 1;
    run(3);
    // R12: reset state
    expect_out("R12 reset enables", 3'b000, 3'b000);
    expect_fb("R12 reset feedback", 1'b1);
    rst = 1'b0;

    // R8: halt gives short brake
    cur_req = "R8";
    run(20);
    expect_out("R8 short brake", 3'b000, 3'b111);

    // R1: forward table, full drive
    cur_req = "R1";
    stop_req = 1'b0; pwm_n = 1'b0;
    for (int c = 0; c < 6; c++) begin
      hall = codes[c]; run(20);
      expect_out("R1 forward table", ehs[c], els[c]);
    end
    // R2: reverse swaps roles
    cur_req = "R2";
    dir_rev = 1'b1;
    for (int c = 0; c < 6; c++) begin
      hall = codes[c]; run(20);
      expect_out("R2 reverse table", els[c], ehs[c]);
    end
    dir_rev = 1'b0;

    // R3: illegal codes
    cur_req = "R3";
    hall = 3'b000; run(2);
    expect_out("R3 code 000 off", 3'b000, 3'b000);
    hall = 3'b001; run(20);
    hall = 3'b111; run(2);
    expect_out("R3 code 111 off", 3'b000, 3'b000);
    stop_req = 1'b1; run(20);
    expect_out("R8 halt over illegal code", 3'b000, 3'b111);
    stop_req = 1'b0;

    // R11: speed feedback follows hall bit 0
    cur_req = "R11";
    hall = 3'b010; run(1);
    expect_fb("R11 feedback low", 1'b0);
    hall = 3'b011; run(1);
    expect_fb("R11 feedback high", 1'b1);
    hall = 3'b001; run(20);

    // R4/R5: qualified PWM, synchronous rectification
    cur_req = "R5";
    pwm_periods(200, 100, 4);
    pwm_n = 1'b0; run(50);
    expect_out("R4 high side on during low pwm", 3'b001, 3'b010);
    run(50);
    pwm_n = 1'b1; run(4);
    expect_out("R7 dead time both off", 3'b000, 3'b010);
    run(46);
    expect_out("R5 sync low side in off time", 3'b000, 3'b011);
    run(50);

    // R6: low frequency disables rectification
    cur_req = "R6";
    pwm_periods(600, 300, 3);
    pwm_n = 1'b0; run(300);
    pwm_n = 1'b1; run(150);
    expect_out("R6 slow pwm no rectification", 3'b000, 3'b010);
    run(150);
    // requalify then low duty
    pwm_periods(200, 100, 3);
    pwm_n = 1'b0; run(100);
    pwm_n = 1'b1; run(50);
    expect_out("R5 requalified rectification", 3'b000, 3'b011);
    run(50);
    pwm_periods(200, 10, 3);
    pwm_n = 1'b0; run(10);
    pwm_n = 1'b1; run(100);
    expect_out("R6 low duty no rectification", 3'b000, 3'b010);
    run(90);

    // R9/R10: protection flags with full drive
    cur_req = "R9";
    pwm_n = 1'b0; run(30);
    flt_stall = 1'b1; run(1);
    expect_out("R9 stall kills high side", 3'b000, 3'b010);
    flt_stall = 1'b0; run(30);
    flt_ilim = 1'b1; run(1);
    expect_out("R9 current limit kills high side", 3'b000, 3'b010);
    flt_ilim = 1'b0; run(30);
    cur_req = "R10";
    flt_uv = 1'b1; stop_req = 1'b1; run(1);
    expect_out("R10 undervoltage all off over halt", 3'b000, 3'b000);
    flt_uv = 1'b0; stop_req = 1'b0; run(30);
    flt_ot = 1'b1; run(1);
    expect_out("R10 overtemperature all off", 3'b000, 3'b000);
    flt_ot = 1'b0; run(30);

    // overlap sweep: stall pulse across the dead-time window after a brake
    cur_req = "R9";
    for (int off = 0; off < 12; off++) begin
      stop_req = 1'b1; run(20);
      stop_req = 1'b0; pwm_n = 1'b0; run(off);
      flt_stall = 1'b1; run(1);
      flt_stall = 1'b0; run(30);
    end
    expect_out("R7 settled after sweep", 3'b001, 3'b010);

    run(5);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
    end
  end
endmodule